// File: doc/BRIEF.md
# Power-of-Two Automatic Gain Control

This block holds the level of a receive chain inside a usable window by scaling the signal entering a demodulator. It watches the samples leaving the demodulator, takes their magnitude, and keeps an attenuation exponent N. A barrel shifter divides every sample entering the demodulator by 2^N with an arithmetic right shift. The exponent moves in whole steps of one, so each gain step is a factor of two. The loop closes through the demodulator: the detector sees the result of the shift that the controller chose.

A loud output sample raises N immediately, one step per offending sample. The attenuation comes down only after the output has stayed quiet for a hold period. At the default 50 kHz sample rate, a hold of 10,000 samples is 0.2 seconds. The hold period, the two thresholds, the sample width and the largest exponent are all parameters. A monitored sample between the two thresholds is treated as normal level. It keeps N where it is and restarts the quiet period.

Top module: `shift_agc`

## Requirements
- R1: After reset, `atten` is 0, `out_valid` is 0 and `out_sample` is 0.
- R2: A monitored sample with `mon_valid` high and magnitude above HI_THR (default 1536) raises `atten` by one, visible on the cycle after that sample.
- R3: `atten` never exceeds N_MAX (default 7); a loud sample when `atten` equals N_MAX leaves it at N_MAX.
- R4: A valid monitored sample whose magnitude is at least LO_THR (default 384) and at most HI_THR leaves `atten` unchanged and restarts the quiet-sample count.
- R5: A valid sample with magnitude below LO_THR is quiet. On the HOLD_LEN-th consecutive quiet valid sample, `atten` falls by one and the quiet count clears.
- R6: When `atten` is 0, a completed quiet period leaves it at 0.
- R7: A loud sample also restarts the quiet-sample count.
- R8: Every valid input sample appears on `out_sample` one cycle later as the two's-complement value shifted right arithmetically by `atten`, rounding toward minus infinity. `out_valid` equals `in_valid` delayed by one cycle.
- R9: An input sample uses the `atten` value held before its own cycle. A change caused by a monitored sample in the same cycle applies from the next input sample onward.
- R10: Monitored samples presented while `mon_valid` is low change neither `atten` nor the quiet-sample count.
- R11: The thresholds are strict. A magnitude of exactly HI_THR is not loud, and exactly LO_THR is not quiet. The most negative sample, -2^(DATA_W-1), is taken at its full magnitude.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_sample | input | DATA_W | Demodulator output sample, two's complement |
| mon_valid | input | 1 | Qualifies `mon_sample` |
| in_sample | input | DATA_W | Demodulator input sample to be scaled, two's complement |
| in_valid | input | 1 | Qualifies `in_sample` |
| out_sample | output | DATA_W | Scaled sample, registered |
| out_valid | output | 1 | Qualifies `out_sample` |
| atten | output | $clog2(N_MAX+1) | Current attenuation exponent N |

## Verification
The bench sweeps every input code through the shifter at every exponent. A design with a logical shift in place of an arithmetic one would turn negative samples large and positive. One that rounded toward zero would be one count off on odd negative values. It probes magnitudes exactly at 384 and 1536, and the code -2048. An off-by-one comparison, or an absolute value that wraps, would move the gain when it should not. Quiet runs one sample short of the hold period, broken by a mid-level or loud sample or stretched by invalid cycles, expose a counter that does not restart, counts invalid samples or releases a sample early or late. The bench also drives the exponent into both rails and pairs a loud monitored sample with an input sample in the same cycle, which catches saturation wrap-around and a shifter that reads the new exponent too soon.

// File: rtl/agc_pkg.sv
package agc_pkg;

    // Classification of one monitored sample
    typedef enum logic [1:0] {
        LVL_QUIET = 2'd0,
        LVL_MID   = 2'd1,
        LVL_LOUD  = 2'd2
    } level_e;

    localparam int unsigned AGC_DATA_W   = 12;
    localparam int unsigned AGC_N_MAX    = 7;
    localparam int unsigned AGC_HI_THR   = 1536;
    localparam int unsigned AGC_LO_THR   = 384;
    localparam int unsigned AGC_HOLD_LEN = 10000;

endpackage

// File: rtl/agc_level_detect.sv
module agc_level_detect
    import agc_pkg::*;
#(
    parameter int unsigned DATA_W = AGC_DATA_W,
    parameter int unsigned HI_THR = AGC_HI_THR,
    parameter int unsigned LO_THR = AGC_LO_THR
) (
    input  logic [DATA_W-1:0] sample,
    output level_e            level
);
    localparam int unsigned MW = DATA_W + 1;
    localparam logic [MW-1:0] HI_V = MW'(HI_THR);
    localparam logic [MW-1:0] LO_V = MW'(LO_THR);

    logic [MW-1:0] mag;

    // One extra bit so the most negative code keeps its full magnitude
    always_comb begin
        if (sample[DATA_W-1]) begin
            mag = {1'b0, ~sample} + MW'(1);
        end else begin
            mag = {1'b0, sample};
        end
    end

    always_comb begin
        if (mag > HI_V) begin
            level = LVL_LOUD;
        end else if (mag < LO_V) begin
            level = LVL_QUIET;
        end else begin
            level = LVL_MID;
        end
    end

endmodule

// File: rtl/agc_gain_ctrl.sv
module agc_gain_ctrl
    import agc_pkg::*;
#(
    parameter int unsigned N_MAX    = AGC_N_MAX,
    parameter int unsigned HOLD_LEN = AGC_HOLD_LEN,
    parameter int unsigned NW       = $clog2(N_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lvl_valid,
    input  level_e        level,
    output logic [NW-1:0] atten
);
    localparam int unsigned HW = $clog2(HOLD_LEN + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_LEN - 1);
    localparam logic [NW-1:0] NMAX_V    = NW'(N_MAX);

    typedef struct packed {
        logic [NW-1:0] atten;
        logic [HW-1:0] hold;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lvl_valid) begin
            unique case (level)
                LVL_LOUD: begin
                    st_d.hold = '0;
                    if (st_q.atten != NMAX_V) begin
                        st_d.atten = st_q.atten + NW'(1);
                    end
                end
                LVL_MID: begin
                    st_d.hold = '0;
                end
                LVL_QUIET: begin
                    if (st_q.hold == HOLD_LAST) begin
                        st_d.hold = '0;
                        if (st_q.atten != '0) begin
                            st_d.atten = st_q.atten - NW'(1);
                        end
                    end else begin
                        st_d.hold = st_q.hold + HW'(1);
                    end
                end
                default: begin
                    st_d.hold = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign atten = st_q.atten;

endmodule

// File: rtl/agc_shifter.sv
module agc_shifter
    import agc_pkg::*;
#(
    parameter int unsigned DATA_W = AGC_DATA_W,
    parameter int unsigned NW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              din_valid,
    input  logic [NW-1:0]     amount,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } sh_t;

    logic signed [DATA_W-1:0] stage [0:NW];
    sh_t sh_d, sh_q;

    assign stage[0] = $signed(din);

    // One logarithmic stage per exponent bit, each a fixed sign-filling shift
    for (genvar k = 0; k < NW; k++) begin : g_stage
        assign stage[k+1] = amount[k] ? (stage[k] >>> (2 ** k)) : stage[k];
    end

    always_comb begin
        sh_d       = sh_q;
        sh_d.valid = din_valid;
        if (din_valid) begin
            sh_d.data = stage[NW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign dout       = sh_q.data;
    assign dout_valid = sh_q.valid;

endmodule

// File: rtl/shift_agc.sv
module shift_agc
    import agc_pkg::*;
#(
    parameter int unsigned DATA_W   = AGC_DATA_W,
    parameter int unsigned N_MAX    = AGC_N_MAX,
    parameter int unsigned HI_THR   = AGC_HI_THR,
    parameter int unsigned LO_THR   = AGC_LO_THR,
    parameter int unsigned HOLD_LEN = AGC_HOLD_LEN,
    parameter int unsigned NW       = $clog2(N_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] mon_sample,
    input  logic              mon_valid,
    input  logic [DATA_W-1:0] in_sample,
    input  logic              in_valid,
    output logic [DATA_W-1:0] out_sample,
    output logic              out_valid,
    output logic [NW-1:0]     atten
);
    level_e mon_level;

    agc_level_detect #(
        .DATA_W (DATA_W),
        .HI_THR (HI_THR),
        .LO_THR (LO_THR)
    ) u_detect (
        .sample (mon_sample),
        .level  (mon_level)
    );

    agc_gain_ctrl #(
        .N_MAX    (N_MAX),
        .HOLD_LEN (HOLD_LEN),
        .NW       (NW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_valid (mon_valid),
        .level     (mon_level),
        .atten     (atten)
    );

    agc_shifter #(
        .DATA_W (DATA_W),
        .NW     (NW)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (in_sample),
        .din_valid  (in_valid),
        .amount     (atten),
        .dout       (out_sample),
        .dout_valid (out_valid)
    );

endmodule

// File: rtl/shift_agc_checker.sv
module shift_agc_checker #(
    parameter int unsigned DATA_W   = 12,
    parameter int unsigned N_MAX    = 7,
    parameter int unsigned HI_THR   = 1536,
    parameter int unsigned LO_THR   = 384,
    parameter int unsigned HOLD_LEN = 10000,
    parameter int unsigned NW       = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] mon_sample,
    input logic              mon_valid,
    input logic [DATA_W-1:0] in_sample,
    input logic              in_valid,
    input logic [DATA_W-1:0] out_sample,
    input logic              out_valid,
    input logic [NW-1:0]     atten
);
    localparam int unsigned HW = $clog2(HOLD_LEN + 1);
    localparam logic [HW-1:0] RUN_LAST = HW'(HOLD_LEN - 1);

    int  mag;
    logic loud, quiet;
    logic [HW-1:0] run_q;

    always_comb begin
        mag   = $signed(mon_sample);
        mag   = (mag < 0) ? -mag : mag;
        loud  = mag > int'(HI_THR);
        quiet = mag < int'(LO_THR);
    end

    // Independent count of consecutive quiet valid samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (mon_valid) begin
            if (quiet && run_q != RUN_LAST) begin
                run_q <= run_q + HW'(1);
            end else begin
                run_q <= '0;
            end
        end
    end

    assert_atten_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(atten) <= int'(N_MAX));

    assert_attack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_valid && loud && int'(atten) < int'(N_MAX)) |=> int'(atten) == int'($past(atten)) + 1);

    assert_attack_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_valid && loud && int'(atten) == int'(N_MAX)) |=> int'(atten) == int'(N_MAX));

    assert_mid_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_valid && !loud && !quiet) |=> $stable(atten));

    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_valid && quiet && run_q == RUN_LAST && atten != '0) |=> int'(atten) == int'($past(atten)) - 1);

    assert_quiet_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_valid && quiet && run_q != RUN_LAST) |=> $stable(atten));

    assert_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_valid && quiet && atten == '0) |=> atten == '0);

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_valid |=> $stable(atten));

    assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_shift_old_n_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> $signed(out_sample) == ($signed($past(in_sample)) >>> $past(atten)));

endmodule

bind shift_agc shift_agc_checker #(
    .DATA_W   (DATA_W),
    .N_MAX    (N_MAX),
    .HI_THR   (HI_THR),
    .LO_THR   (LO_THR),
    .HOLD_LEN (HOLD_LEN),
    .NW       (NW)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .mon_sample (mon_sample),
    .mon_valid  (mon_valid),
    .in_sample  (in_sample),
    .in_valid   (in_valid),
    .out_sample (out_sample),
    .out_valid  (out_valid),
    .atten      (atten)
);

// File: tb/tb_shift_agc.sv
module tb_shift_agc;
    localparam int DW   = 12;
    localparam int NMAX = 7;
    localparam int HOLD = 12;
    localparam int NWID = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [DW-1:0]   mon_sample = '0;
    logic            mon_valid = 1'b0;
    logic [DW-1:0]   in_sample = '0;
    logic            in_valid = 1'b0;
    logic [DW-1:0]   out_sample;
    logic            out_valid;
    logic [NWID-1:0] atten;

    int n_chk = 0;
    int n_bad = 0;
    int m_att = 0;
    int m_hold = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    shift_agc #(
        .DATA_W   (DW),
        .N_MAX    (NMAX),
        .HI_THR   (1536),
        .LO_THR   (384),
        .HOLD_LEN (HOLD)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mon_sample (mon_sample),
        .mon_valid  (mon_valid),
        .in_sample  (in_sample),
        .in_valid   (in_valid),
        .out_sample (out_sample),
        .out_valid  (out_valid),
        .atten      (atten)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference update straight from the requirement text
    task automatic model(input int v);
        int m;
        m = (v < 0) ? -v : v;
        if (m > 1536) begin
            m_hold = 0;
            if (m_att < NMAX) m_att++;
        end else if (m >= 384) begin
            m_hold = 0;
        end else begin
            m_hold++;
            if (m_hold == HOLD) begin
                m_hold = 0;
                if (m_att > 0) m_att--;
            end
        end
    endtask

    task automatic mon(input int v);
        mon_sample = DW'(v);
        mon_valid  = 1'b1;
        model(v);
        @(negedge clk);
        mon_valid  = 1'b0;
    endtask

    task automatic quiet_run(input int cnt);
        for (int i = 0; i < cnt; i++) mon((i % 2 == 0) ? 383 : -383);
    endtask

    initial begin
        #1600000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!finished) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 atten", int'(atten), 0);
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_sample", int'(out_sample), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 boundaries at N=0
        mon(1536);  check("R11 +1536 not loud", int'(atten), 0);
        mon(-1536); check("R11 -1536 not loud", int'(atten), 0);

        // R8 full sweep at every exponent, R2 stepping between them
        for (int n = 0; n <= NMAX; n++) begin
            for (int v = -2048; v < 2048; v++) begin
                in_sample = DW'(v);
                in_valid  = 1'b1;
                @(negedge clk);
                check("R8 shift", int'($signed(out_sample)), v >>> n);
                check("R8 valid", int'(out_valid), 1);
            end
            in_valid = 1'b0;
            @(negedge clk);
            check("R8 valid drop", int'(out_valid), 0);
            if (n < NMAX) begin
                mon((n % 2 == 0) ? 1537 : -2048);
                check("R2 attack R11", int'(atten), n + 1);
            end
        end
        mon(1537);  check("R3 saturate", int'(atten), NMAX);
        mon(-2048); check("R3 saturate neg", int'(atten), NMAX);

        // R5 release timing
        quiet_run(HOLD - 1); check("R5 one short", int'(atten), 7);
        quiet_run(1);        check("R5 release", int'(atten), 6);
        // R4 / R11 mid sample restarts the count
        quiet_run(HOLD - 1); mon(384); check("R4 mid keeps", int'(atten), 6);
        quiet_run(HOLD - 1); check("R4 restarted", int'(atten), 6);
        quiet_run(1);        check("R4 release after", int'(atten), 5);
        // R7 loud sample restarts the count
        quiet_run(HOLD - 1); mon(-1600); check("R7 attack", int'(atten), 6);
        quiet_run(HOLD - 1); check("R7 restarted", int'(atten), 6);
        quiet_run(1);        check("R7 release", int'(atten), 5);
        // R10 invalid cycles neither count nor reset
        quiet_run(HOLD - 1);
        mon_sample = DW'(2000);
        repeat (5) @(negedge clk);
        check("R10 idle loud", int'(atten), 5);
        mon_sample = DW'(10);
        repeat (5) @(negedge clk);
        check("R10 idle quiet", int'(atten), 5);
        quiet_run(1); check("R10 count kept", int'(atten), 4);

        // R9 same-cycle update
        in_sample = DW'(-100); in_valid = 1'b1;
        mon_sample = DW'(1600); mon_valid = 1'b1; model(1600);
        @(negedge clk);
        mon_valid = 1'b0;
        check("R9 old exponent", int'($signed(out_sample)), -100 >>> 4);
        check("R9 atten", int'(atten), 5);
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 new exponent", int'($signed(out_sample)), -100 >>> 5);

        // R6 walk to the floor and stay
        for (int k = 4; k >= 0; k--) begin
            quiet_run(HOLD); check("R5 walk down", int'(atten), k);
        end
        quiet_run(HOLD);     check("R6 floor", int'(atten), 0);
        quiet_run(3 * HOLD); check("R6 floor long", int'(atten), 0);

        // Model-driven sweep over every monitored code, padded with quiet runs
        m_hold = 0;
        mon(500);
        for (int i = 0; i < 4096; i++) begin
            mon(((i * 37) % 4096) - 2048);
            check("R2 R4 R5 model", int'(atten), m_att);
            quiet_run(i % 13);
            check("R5 R6 model", int'(atten), m_att);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule